// File: doc/BRIEF.md
# High-Voltage Programming Mode Entry Sequencer

This block sits on the host side of a programming link. It brings a target device into its high-voltage serial programming mode, and later powers it down in a safe order. It drives digital enables for the analog switches: target supply, a pull of the target reset pin to ground, and the switch that puts the programming high voltage on that reset pin. It also drives the serial clock line and one output enable for each of the three mode-select pins. When an enable is set, the host drives that pin low.

A one-cycle `start_req` pulse in the idle state starts the entry sequence. Every wait in the sequence is counted in system clocks, and each wait length is a parameter. When the target may accept serial instructions, `prog_ready` goes high. A one-cycle `exit_req` pulse in that state starts the power-down order. Frame shifting and command sequences belong to a separate block, which runs only while `prog_ready` is high.

The states and their exits:
- ST_IDLE goes to ST_PWR on start.
- ST_PWR goes to ST_SCI when its timer runs out.
- ST_SCI goes to ST_SEL after the last clock pulse.
- ST_SEL, ST_LATCH and ST_SETTLE each go to the next state on timer expiry, ending in ST_READY.
- ST_READY goes to ST_OFF_SCI on exit.
- ST_OFF_SCI goes to ST_OFF_HV, and ST_OFF_HV goes back to ST_IDLE, each on timer expiry.

Top module: `hv_entry_seq`

## Requirements
- R1: After reset, and in the idle state, all outputs are low: `supply_en`, `rst_drive_low`, `hv_en`, `sci_out`, `pin_oe` = 000 and `prog_ready`.
- R2: A start pulse in idle sets `supply_en` and `rst_drive_low` together on the next edge. Both stay high with `hv_en` low and `pin_oe` = 000 for PWR_CYC cycles, followed by the clock-toggle phase.
- R3: In the toggle phase, `sci_out` makes exactly SCI_PULSES high pulses. Each high and each low half lasts SCI_HALF cycles. The phase ends with `sci_out` low, one cycle after the last falling edge.
- R4: Next, `pin_oe` = 111 (bit 0 data-in pin, bit 1 instruction-in pin, bit 2 data-out pin) for SEL_CYC cycles. Then on a single edge `rst_drive_low` clears and `hv_en` sets. `rst_drive_low` and `hv_en` are never high together.
- R5: `pin_oe` stays 111 for LATCH_CYC cycles after `hv_en` rises. Then bit 2 alone clears, so `pin_oe` = 011.
- R6: `prog_ready` rises SETTLE_CYC cycles after the data-out pin is released. It is high only in the entered state, with `hv_en` high and `pin_oe` = 011.
- R7: An exit pulse in the entered state clears `prog_ready` and `pin_oe` on the next edge, with `sci_out` low. `hv_en` and `supply_en` stay on for OFF_CYC cycles. Then `hv_en` clears, and OFF_CYC cycles later `supply_en` clears.
- R8: A start pulse outside idle has no effect on any output or on the timing of the sequence.
- R9: An exit pulse outside the entered state has no effect on any output or on the timing.
- R10: `sci_out` is high only in the toggle phase, that is while `supply_en` and `rst_drive_low` are high and `pin_oe` = 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all delays count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | One-cycle request to enter programming mode |
| exit_req | input | 1 | One-cycle request to power the target down |
| supply_en | output | 1 | Enables the target supply switch |
| rst_drive_low | output | 1 | Pulls the target reset pin to ground |
| hv_en | output | 1 | Switches the high voltage onto the target reset pin |
| sci_out | output | 1 | Serial clock line to the target |
| pin_oe | output | 3 | Drive-low enables: [0] data-in, [1] instruction-in, [2] data-out |
| prog_ready | output | 1 | Serial instructions may now be issued |

## Verification
The assertions assume that `start_req` and `exit_req` are synchronous to `clk`. They also assume that any pulse is sampled on a rising edge, and that no request arrives in the same cycle as reset release. The bench changes every input only on falling edges and holds each request for exactly one cycle. It also places requests deliberately inside the timed phases, so the ignore rules are exercised by in-range stimulus.

// File: rtl/hvp_pkg.sv
package hvp_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PWR,
        ST_SCI,
        ST_SEL,
        ST_LATCH,
        ST_SETTLE,
        ST_READY,
        ST_OFF_SCI,
        ST_OFF_HV
    } hvp_state_e;

    typedef struct packed {
        logic       supply;
        logic       rst_low;
        logic       hv;
        logic [2:0] oe;
        logic       ready;
    } hvp_drive_t;

endpackage

// File: rtl/hvp_timer.sv
module hvp_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/hvp_sci_gen.sv
module hvp_sci_gen #(
    parameter int HALF   = 4,
    parameter int PULSES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic sci,
    output logic done
);

    localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int PW = $clog2(PULSES + 1);
    localparam logic [HW-1:0] HALF_LAST = HW'(HALF - 1);
    localparam logic [PW-1:0] PULSE_MAX = PW'(PULSES);

    logic [HW-1:0] half_q;
    logic [PW-1:0] pulse_q;
    logic          sci_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q  <= '0;
            pulse_q <= '0;
            sci_q   <= 1'b0;
        end else if (!en) begin
            half_q  <= '0;
            pulse_q <= '0;
            sci_q   <= 1'b0;
        end else if (pulse_q != PULSE_MAX) begin
            if (half_q == HALF_LAST) begin
                half_q <= '0;
                sci_q  <= ~sci_q;
                if (sci_q) begin
                    pulse_q <= pulse_q + 1'b1;
                end
            end else begin
                half_q <= half_q + 1'b1;
            end
        end
    end

    assign sci  = sci_q;
    assign done = (pulse_q == PULSE_MAX);

endmodule

// File: rtl/hv_entry_seq.sv
module hv_entry_seq
    import hvp_pkg::*;
#(
    parameter int PWR_CYC    = 64,
    parameter int SCI_HALF   = 4,
    parameter int SCI_PULSES = 6,
    parameter int SEL_CYC    = 16,
    parameter int LATCH_CYC  = 16,
    parameter int SETTLE_CYC = 5000,
    parameter int OFF_CYC    = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       exit_req,
    output logic       supply_en,
    output logic       rst_drive_low,
    output logic       hv_en,
    output logic       sci_out,
    output logic [2:0] pin_oe,
    output logic       prog_ready
);

    localparam int M1   = (PWR_CYC > SEL_CYC) ? PWR_CYC : SEL_CYC;
    localparam int M2   = (LATCH_CYC > SETTLE_CYC) ? LATCH_CYC : SETTLE_CYC;
    localparam int M3   = (M1 > M2) ? M1 : M2;
    localparam int TMAX = (M3 > OFF_CYC) ? M3 : OFF_CYC;
    localparam int TW   = $clog2(TMAX + 1);

    hvp_state_e state_q, state_d;
    hvp_drive_t drv;
    logic       t_expired;
    logic       t_load;
    logic [TW-1:0] t_val;
    logic       sci_en;
    logic       sci_done;

    // Dwell length of the state being entered; the timer holds length-1.
    function automatic logic [TW-1:0] dwell_of(hvp_state_e s);
        int d;
        unique case (s)
            ST_PWR:     d = PWR_CYC;
            ST_SEL:     d = SEL_CYC;
            ST_LATCH:   d = LATCH_CYC;
            ST_SETTLE:  d = SETTLE_CYC;
            ST_OFF_SCI: d = OFF_CYC;
            ST_OFF_HV:  d = OFF_CYC;
            default:    d = 1;
        endcase
        return TW'(d - 1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_req) state_d = ST_PWR;
            ST_PWR:     if (t_expired) state_d = ST_SCI;
            ST_SCI:     if (sci_done)  state_d = ST_SEL;
            ST_SEL:     if (t_expired) state_d = ST_LATCH;
            ST_LATCH:   if (t_expired) state_d = ST_SETTLE;
            ST_SETTLE:  if (t_expired) state_d = ST_READY;
            ST_READY:   if (exit_req)  state_d = ST_OFF_SCI;
            ST_OFF_SCI: if (t_expired) state_d = ST_OFF_HV;
            ST_OFF_HV:  if (t_expired) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    assign t_load = (state_d != state_q);
    assign t_val  = dwell_of(state_d);
    assign sci_en = (state_q == ST_SCI);

    always_comb begin
        drv = '0;
        unique case (state_q)
            ST_IDLE:    drv = '0;
            ST_PWR:     begin drv.supply = 1'b1; drv.rst_low = 1'b1; end
            ST_SCI:     begin drv.supply = 1'b1; drv.rst_low = 1'b1; end
            ST_SEL:     begin drv.supply = 1'b1; drv.rst_low = 1'b1; drv.oe = 3'b111; end
            ST_LATCH:   begin drv.supply = 1'b1; drv.hv = 1'b1; drv.oe = 3'b111; end
            ST_SETTLE:  begin drv.supply = 1'b1; drv.hv = 1'b1; drv.oe = 3'b011; end
            ST_READY:   begin drv.supply = 1'b1; drv.hv = 1'b1; drv.oe = 3'b011; drv.ready = 1'b1; end
            ST_OFF_SCI: begin drv.supply = 1'b1; drv.hv = 1'b1; end
            ST_OFF_HV:  begin drv.supply = 1'b1; end
            default:    drv = '0;
        endcase
    end

    hvp_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    hvp_sci_gen #(.HALF(SCI_HALF), .PULSES(SCI_PULSES)) u_sci (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sci_en),
        .sci   (sci_out),
        .done  (sci_done)
    );

    assign supply_en     = drv.supply;
    assign rst_drive_low = drv.rst_low;
    assign hv_en         = drv.hv;
    assign pin_oe        = drv.oe;
    assign prog_ready    = drv.ready;

endmodule

// File: rtl/hv_entry_seq_chk.sv
module hv_entry_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_req,
    input logic       exit_req,
    input logic       supply_en,
    input logic       rst_drive_low,
    input logic       hv_en,
    input logic       sci_out,
    input logic [2:0] pin_oe,
    input logic       prog_ready
);

    AST_RST_HV_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_drive_low && hv_en)); // R4

    AST_HV_RISE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hv_en) |-> (pin_oe == 3'b111) && ($past(pin_oe) == 3'b111)); // R4

    AST_RELEASE_DATA_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pin_oe) == 3'b111) && (pin_oe != 3'b111) && hv_en |-> pin_oe == 3'b011); // R5

    AST_READY_CONTEXT: assert property (@(posedge clk) disable iff (!rst_n)
        prog_ready |-> hv_en && supply_en && (pin_oe == 3'b011) && !sci_out); // R6

    AST_EXIT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        prog_ready && exit_req |=> !prog_ready && hv_en && (pin_oe == 3'b000)); // R7

    AST_SUPPLY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(supply_en) |-> !hv_en && !rst_drive_low && $past(!hv_en)); // R7

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        prog_ready && start_req && !exit_req |=> prog_ready); // R8

    AST_SCI_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        sci_out |-> supply_en && rst_drive_low && (pin_oe == 3'b000)); // R10

endmodule

bind hv_entry_seq hv_entry_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_req     (start_req),
    .exit_req      (exit_req),
    .supply_en     (supply_en),
    .rst_drive_low (rst_drive_low),
    .hv_en         (hv_en),
    .sci_out       (sci_out),
    .pin_oe        (pin_oe),
    .prog_ready    (prog_ready)
);

// File: tb/test_hv_entry_seq.sv
module test_hv_entry_seq;

    localparam int PWR_CYC    = 64;
    localparam int SCI_HALF   = 4;
    localparam int SCI_PULSES = 6;
    localparam int SEL_CYC    = 16;
    localparam int LATCH_CYC  = 16;
    localparam int SETTLE_CYC = 5000;
    localparam int OFF_CYC    = 32;
    localparam int PH0_DWELL  = PWR_CYC + 2 * SCI_HALF * SCI_PULSES + 1;

    // {supply, rst_low, hv, oe[2:0], ready} , dwell (0 = held until a request)
    localparam logic [22:0] PHASES [8] = '{
        {7'b1100000, 16'(PH0_DWELL)},   // R2 power + clock toggle
        {7'b1101110, 16'(SEL_CYC)},     // R4 pins driven low
        {7'b1011110, 16'(LATCH_CYC)},   // R5 high voltage latch
        {7'b1010110, 16'(SETTLE_CYC)},  // R6 data-out released
        {7'b1010111, 16'd0},            // R6 entered
        {7'b1010000, 16'(OFF_CYC)},     // R7 clock low, pins released
        {7'b1000000, 16'(OFF_CYC)},     // R7 high voltage off
        {7'b0000000, 16'd0}             // R7 supply off
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 1'b0;
    logic exit_req = 1'b0;
    logic supply_en, rst_drive_low, hv_en, sci_out, prog_ready;
    logic [2:0] pin_oe;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int sci_rises = 0;
    int sci_high = 0;
    int sci_stray = 0;
    logic sci_prev = 1'b0;

    wire [6:0] bun = {supply_en, rst_drive_low, hv_en, pin_oe, prog_ready};

    always #4 clk = ~clk;

    hv_entry_seq #(
        .PWR_CYC(PWR_CYC), .SCI_HALF(SCI_HALF), .SCI_PULSES(SCI_PULSES),
        .SEL_CYC(SEL_CYC), .LATCH_CYC(LATCH_CYC), .SETTLE_CYC(SETTLE_CYC),
        .OFF_CYC(OFF_CYC)
    ) i_hv_entry_seq (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .exit_req(exit_req),
        .supply_en(supply_en), .rst_drive_low(rst_drive_low), .hv_en(hv_en),
        .sci_out(sci_out), .pin_oe(pin_oe), .prog_ready(prog_ready)
    );

    always @(negedge clk) begin
        cycles <= cycles + 1;
        sci_prev <= sci_out;
        if (sci_out && !sci_prev) sci_rises <= sci_rises + 1;
        if (sci_out) sci_high <= sci_high + 1;
        if (sci_out && bun != 7'b1100000) sci_stray <= sci_stray + 1;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual=%0d expected<150000", cycles);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
    endtask

    initial begin
        logic [6:0] prev;
        logic [6:0] cur;
        int cnt;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {25'd0, bun}, 32'h0);
        check("R1 reset sci", {31'd0, sci_out}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: exit while idle has no effect
        exit_req = 1'b1;
        @(negedge clk);
        exit_req = 1'b0;
        repeat (5) @(negedge clk);
        check("R9 exit in idle", {25'd0, bun}, 32'h0);

        prev = bun;
        pulse_start();
        for (int i = 0; i < 8; i++) begin
            while (bun == prev) @(negedge clk);
            cur = bun;
            check($sformatf("R2-R7 phase %0d outputs", i), {25'd0, cur}, {25'd0, PHASES[i][22:16]});
            if (PHASES[i][15:0] != 16'd0) begin
                cnt = 1;
                @(negedge clk);
                while (bun == cur) begin
                    cnt++;
                    if (i == 1 && cnt == 3) start_req = 1'b1;   // R8 mid-sequence start
                    else if (i == 1 && cnt == 4) start_req = 1'b0;
                    if (i == 3 && cnt == 5) exit_req = 1'b1;    // R9 early exit
                    else if (i == 3 && cnt == 6) exit_req = 1'b0;
                    @(negedge clk);
                end
                check($sformatf("R2-R7 phase %0d dwell", i), cnt, {16'd0, PHASES[i][15:0]});
            end
            if (i == 0) begin
                check("R3 sci pulse count", sci_rises, SCI_PULSES);
                check("R3 sci high cycles", sci_high, SCI_HALF * SCI_PULSES);
                check("R3 sci ends low", {31'd0, sci_out}, 32'h0);
            end
            if (i == 4) begin
                pulse_start();
                repeat (10) @(negedge clk);
                check("R8 start in ready", {25'd0, bun}, {25'd0, cur});
                exit_req = 1'b1;
                @(negedge clk);
                exit_req = 1'b0;
            end
            prev = cur;
        end
        check("R10 sci outside toggle phase", sci_stray, 0);
        check("R3 no extra pulses", sci_rises, SCI_PULSES);

        // R1: reset in the middle of the sequence returns to idle outputs
        pulse_start();
        repeat (PH0_DWELL + SEL_CYC + 4) @(negedge clk);
        check("R4 mid latch hv", {31'd0, hv_en}, 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-sequence", {25'd0, bun}, 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle after reset", {25'd0, bun}, 32'h0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule